// File: doc/BRIEF.md
# Serial Configuration Register Port with Auto-Increment

This block takes a three-wire, write-only serial stream and turns it into a small bank of 12-bit control registers. The three lines are an active-low load strobe, a serial clock and a data line. Each frame begins with a 4-bit register address and continues with one or more 12-bit data words. Both fields are sent least significant bit first. The address steps up by one after every complete word, so a host can fill neighbouring registers in one frame.

Received words go into shadow copies first. The live registers take the shadow values only when the load strobe rises. That gives the downstream logic one coherent update per frame. Five addresses are decoded: operation, control, black-clamp level, gain and a start-up register. The operation register has a self-clearing reset bit and a 2-bit power-mode field.

After a hardware reset the port stays busy for a parameterised number of cycles. Any frame that begins in that window is dropped. The serial lines are sampled in the system clock domain after a two-stage synchroniser.

Top module: `cfg_serial_port`

## Requirements
- R1: After reset every register reads 0, except the clamp register, which reads 128 (0x080). `busy` is 1.
- R2: `busy` stays 1 for BUSY_CYCLES system clocks after reset, then goes to 0 and stays 0. A frame that starts while `busy` is 1 has no effect on any register.
- R3: Bits are taken on each rising edge of `sclk` while `sload_n` is low. The first 4 bits are address A0..A3 and the next 12 bits are data D0..D11, each field LSB first.
- R4: A received word changes no output until `sload_n` rises. On that rise the outputs take every word staged so far.
- R5: Each further 12-bit word in the same frame goes to the next address. The 4-bit address wraps from 15 to 0.
- R6: A word that is incomplete when `sload_n` rises is discarded. Earlier complete words of the frame are still committed.
- R7: Addresses other than 0 (operation), 1 (control), 2 (clamp), 3 (gain) and 13 (start-up) are ignored.
- R8: Committing an operation value with bit 0 set returns all registers, live and staged, to their reset values.
- R9: `pwr_mode` equals operation bits [2:1]: 00 is normal, 01 is standby and 10 is shutdown.
- R10: `sclk` edges while `sload_n` is high change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sload_n | input | 1 | Frame strobe; low while shifting, rising edge commits |
| sclk | input | 1 | Serial bit clock |
| sdata | input | 1 | Serial data |
| busy | output | 1 | Power-on lockout active |
| op_reg | output | 12 | Live operation register |
| ctrl_reg | output | 12 | Live control register |
| clamp_reg | output | 12 | Live clamp-level register |
| gain_reg | output | 12 | Live gain register |
| start_reg | output | 12 | Live start-up register |
| pwr_mode | output | 2 | Power-mode field of the operation register |

## Verification
The bench sends one frame that wraps from address 15 to 0 while passing through undecoded addresses. A design that failed to wrap, or that stored ignored addresses, would corrupt the operation register. It ends another frame seven bits into a word. A design that kept partial bits would load a garbage gain value, or one that dropped the whole frame would lose the good word before it. It also sends a frame inside the busy window, and checks the outputs before every strobe rise to catch a bank that updates early. The software-reset frame writes a second register in the same frame to confirm that the reset overrides it.

// File: rtl/cfg_pkg.sv
package cfg_pkg;
  localparam int REG_W  = 12;
  localparam int ADDR_W = 4;

  typedef enum logic [ADDR_W-1:0] {
    A_OP    = 4'd0,
    A_CTRL  = 4'd1,
    A_CLAMP = 4'd2,
    A_GAIN  = 4'd3,
    A_START = 4'd13
  } reg_addr_e;

  typedef struct packed {
    logic [REG_W-1:0] op;
    logic [REG_W-1:0] ctrl;
    logic [REG_W-1:0] clamp;
    logic [REG_W-1:0] gain;
    logic [REG_W-1:0] start;
  } bank_t;

  localparam logic [REG_W-1:0] CLAMP_DEF = 12'd128;

  function automatic bank_t bank_default();
    bank_t b;
    b       = '0;
    b.clamp = CLAMP_DEF;
    return b;
  endfunction

  function automatic logic [1:0] pwr_field(input logic [REG_W-1:0] op);
    return op[2:1];
  endfunction
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int         W       = 3,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout,
  output logic [W-1:0] rise
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic s1, s2, s3;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        s1 <= RST_VAL[i];
        s2 <= RST_VAL[i];
        s3 <= RST_VAL[i];
      end else begin
        s1 <= din[i];
        s2 <= s1;
        s3 <= s2;
      end
    end
    assign dout[i] = s2;
    assign rise[i] = s2 & ~s3;
  end
endmodule

// File: rtl/cfg_deser.sv
module cfg_deser
  import cfg_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = REG_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          arm_en,
  input  logic          load_hi,
  input  logic          sck_rise,
  input  logic          sd,
  output logic          word_stb,
  output logic [AW-1:0] word_addr,
  output logic [DW-1:0] word_data
);
  localparam int CW = $clog2(DW);

  logic          armed, addr_ph;
  logic [CW-1:0] cnt;
  logic [AW-1:0] ash, cur_addr;
  logic [DW-1:0] dsh;
  logic          take_bit;

  assign take_bit = armed & ~load_hi & sck_rise;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed     <= 1'b0;
      addr_ph   <= 1'b1;
      cnt       <= '0;
      ash       <= '0;
      cur_addr  <= '0;
      dsh       <= '0;
      word_stb  <= 1'b0;
      word_addr <= '0;
      word_data <= '0;
    end else begin
      word_stb <= 1'b0;
      if (!arm_en)      armed <= 1'b0;
      else if (load_hi) armed <= 1'b1;
      if (load_hi || !armed) begin
        addr_ph <= 1'b1;
        cnt     <= '0;
      end else if (take_bit) begin
        if (addr_ph) begin
          ash <= {sd, ash[AW-1:1]};
          if (cnt == CW'(AW-1)) begin
            cur_addr <= {sd, ash[AW-1:1]};
            addr_ph  <= 1'b0;
            cnt      <= '0;
          end else cnt <= cnt + 1'b1;
        end else begin
          dsh <= {sd, dsh[DW-1:1]};
          if (cnt == CW'(DW-1)) begin
            word_stb  <= 1'b1;
            word_addr <= cur_addr;
            word_data <= {sd, dsh[DW-1:1]};
            cur_addr  <= cur_addr + 1'b1;
            cnt       <= '0;
          end else cnt <= cnt + 1'b1;
        end
      end
    end
  end

  p_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    load_hi |=> !word_stb);
endmodule

// File: rtl/cfg_bank.sv
module cfg_bank
  import cfg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              word_stb,
  input  logic [ADDR_W-1:0] word_addr,
  input  logic [REG_W-1:0]  word_data,
  input  logic              commit,
  output bank_t             live
);
  bank_t shadow;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shadow <= bank_default();
      live   <= bank_default();
    end else if (word_stb) begin
      case (word_addr)
        A_OP:    shadow.op    <= word_data;
        A_CTRL:  shadow.ctrl  <= word_data;
        A_CLAMP: shadow.clamp <= word_data;
        A_GAIN:  shadow.gain  <= word_data;
        A_START: shadow.start <= word_data;
        default: ;
      endcase
    end else if (commit) begin
      if (shadow.op[0]) begin
        shadow <= bank_default();
        live   <= bank_default();
      end else begin
        live <= shadow;
      end
    end
  end

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !commit |=> live == $past(live));
  p_take_r4: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !word_stb && !shadow.op[0] |=> live == $past(shadow));
  p_swrst_r8: assert property (@(posedge clk) disable iff (!rst_n)
    commit && !word_stb && shadow.op[0] |=> live == bank_default());
endmodule

// File: rtl/cfg_serial_port.sv
module cfg_serial_port
  import cfg_pkg::*;
#(
  parameter int BUSY_CYCLES = 250000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sload_n,
  input  logic             sclk,
  input  logic             sdata,
  output logic             busy,
  output logic [REG_W-1:0] op_reg,
  output logic [REG_W-1:0] ctrl_reg,
  output logic [REG_W-1:0] clamp_reg,
  output logic [REG_W-1:0] gain_reg,
  output logic [REG_W-1:0] start_reg,
  output logic [1:0]       pwr_mode
);
  localparam int PW = $clog2(BUSY_CYCLES + 1);

  logic [PW-1:0]       por_cnt;
  logic [2:0]          s_lvl, s_rise;
  logic                word_stb, commit;
  logic [ADDR_W-1:0]   word_addr;
  logic [REG_W-1:0]    word_data;
  bank_t               live;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     por_cnt <= '0;
    else if (busy)  por_cnt <= por_cnt + 1'b1;
  end
  assign busy = (por_cnt != PW'(BUSY_CYCLES));

  // bit 0: strobe, bit 1: serial clock, bit 2: data
  cfg_sync #(.W(3), .RST_VAL(3'b001)) u_sync (
    .clk(clk), .rst_n(rst_n), .din({sdata, sclk, sload_n}),
    .dout(s_lvl), .rise(s_rise));

  cfg_deser u_deser (
    .clk(clk), .rst_n(rst_n), .arm_en(~busy), .load_hi(s_lvl[0]),
    .sck_rise(s_rise[1]), .sd(s_lvl[2]),
    .word_stb(word_stb), .word_addr(word_addr), .word_data(word_data));

  assign commit = s_rise[0] & ~busy;

  cfg_bank u_bank (
    .clk(clk), .rst_n(rst_n), .word_stb(word_stb), .word_addr(word_addr),
    .word_data(word_data), .commit(commit), .live(live));

  assign op_reg    = live.op;
  assign ctrl_reg  = live.ctrl;
  assign clamp_reg = live.clamp;
  assign gain_reg  = live.gain;
  assign start_reg = live.start;
  assign pwr_mode  = pwr_field(live.op);

  p_busy_mono_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !busy);
  p_busy_nowrite_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !word_stb);
  p_pwr_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_mode == op_reg[2:1]);
endmodule

// File: tb/tb_cfg_serial_port.sv
module tb_cfg_serial_port;
  localparam int BUSY = 300;

  typedef struct {
    logic [11:0] op, ctrl, clamp, gain, start;
  } snap_t;

  logic clk = 0, rst_n = 0, sload_n = 1, sclk = 0, sdata = 0;
  logic busy;
  logic [11:0] op_reg, ctrl_reg, clamp_reg, gain_reg, start_reg;
  logic [1:0]  pwr_mode;

  int tests = 0, fails = 0;
  bit done = 0;
  snap_t sh_m, live_m;
  snap_t expq[$];

  always #2 clk = ~clk;

  cfg_serial_port #(.BUSY_CYCLES(BUSY)) dut (
    .clk(clk), .rst_n(rst_n), .sload_n(sload_n), .sclk(sclk), .sdata(sdata),
    .busy(busy), .op_reg(op_reg), .ctrl_reg(ctrl_reg), .clamp_reg(clamp_reg),
    .gain_reg(gain_reg), .start_reg(start_reg), .pwr_mode(pwr_mode));

  function automatic snap_t defaults();
    snap_t s;
    s.op = 0; s.ctrl = 0; s.clamp = 12'd128; s.gain = 0; s.start = 0;
    return s;
  endfunction

  task automatic check(input string req, input snap_t e);
    tests++;
    if (op_reg !== e.op || ctrl_reg !== e.ctrl || clamp_reg !== e.clamp ||
        gain_reg !== e.gain || start_reg !== e.start || pwr_mode !== e.op[2:1]) begin
      fails++;
      $display("FAIL %s: got op=%h ctrl=%h clamp=%h gain=%h start=%h pwr=%b exp op=%h ctrl=%h clamp=%h gain=%h start=%h pwr=%b",
               req, op_reg, ctrl_reg, clamp_reg, gain_reg, start_reg, pwr_mode,
               e.op, e.ctrl, e.clamp, e.gain, e.start, e.op[2:1]);
    end
  endtask

  task automatic check_bit(input string req, input logic got, input logic exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %b exp %b", req, got, exp);
    end
  endtask

  function automatic void mwrite(input logic [3:0] a, input logic [11:0] v);
    case (a)
      4'd0:  sh_m.op    = v;
      4'd1:  sh_m.ctrl  = v;
      4'd2:  sh_m.clamp = v;
      4'd3:  sh_m.gain  = v;
      4'd13: sh_m.start = v;
      default: ;
    endcase
  endfunction

  task automatic send_bits(input logic [11:0] v, input int n);
    for (int i = 0; i < n; i++) begin
      sdata = v[i];
      sclk  = 0;
      repeat (4) @(negedge clk);
      sclk  = 1;
      repeat (4) @(negedge clk);
    end
  endtask

  // driver: sends a frame, updates the model and pushes the expected snapshot
  task automatic frame(input string req, input logic [3:0] addr, input int n,
                       input logic [11:0] w [8], input int pbits, input bit locked);
    logic [3:0] a;
    a = addr;
    sload_n = 0;
    repeat (4) @(negedge clk);
    send_bits({8'h0, addr}, 4);
    for (int k = 0; k < n; k++) begin
      send_bits(w[k], 12);
      if (!locked) mwrite(a, w[k]);
      a = a + 4'd1;
    end
    if (pbits > 0) send_bits(12'hFFF, pbits);      // R6 partial word
    sclk = 0;
    repeat (10) @(negedge clk);
    check({"R4 before strobe, ", req}, live_m);      // R4: nothing committed yet
    if (!locked) begin
      live_m = sh_m;
      if (live_m.op[0]) begin sh_m = defaults(); live_m = defaults(); end
    end
    expq.push_back(live_m);
    sload_n = 1;
    repeat (16) @(negedge clk);
  endtask

  // monitor: pops expected snapshots after each strobe rise
  initial begin
    forever begin
      @(posedge sload_n);
      repeat (10) @(negedge clk);
      if (expq.size() > 0) check("commit (R3/R5/R6/R7/R8/R9)", expq.pop_front());
    end
  end

  initial begin
    #(4 * 150000);
    fails++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [11:0] w [8];
    sh_m = defaults();
    live_m = defaults();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1 reset values", defaults());
    check_bit("R1 busy after reset", busy, 1'b1);

    // R2: frame inside the lockout is ignored
    w = '{12'h5A5, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0};
    frame("R2 locked", 4'd1, 1, w, 0, 1);
    repeat (BUSY) @(negedge clk);
    check_bit("R2 busy released", busy, 1'b0);

    // R3: single word to control
    w = '{12'h07F, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0};
    frame("R3 single", 4'd1, 1, w, 0, 0);

    // R5/R9: four words from address 0, shutdown power mode
    w = '{12'h004, 12'h011, 12'h0AB, 12'h3FF, 12'h0, 12'h0, 12'h0, 12'h0};
    frame("R5 burst", 4'd0, 4, w, 0, 0);

    // R5/R7: start at 12, through undecoded 14/15, wrap to 0 (standby)
    w = '{12'h111, 12'h838, 12'h222, 12'h333, 12'h002, 12'h0, 12'h0, 12'h0};
    frame("R7 wrap", 4'd12, 5, w, 0, 0);

    // R6: one full word to gain, then 7 stray bits
    w = '{12'h155, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0};
    frame("R6 partial", 4'd3, 1, w, 7, 0);

    // R6: frame with only a partial word changes nothing
    frame("R6 only partial", 4'd2, 0, w, 9, 0);

    // R10: serial clock toggling while strobe is high
    for (int i = 0; i < 20; i++) begin
      sdata = i[0];
      sclk = ~sclk;
      repeat (4) @(negedge clk);
    end
    sclk = 0;
    repeat (10) @(negedge clk);
    check("R10 clock while idle", live_m);

    // R8: software reset overrides a same-frame control write
    w = '{12'h001, 12'h3C0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0};
    frame("R8 soft reset", 4'd0, 2, w, 0, 0);

    // R3: port still works after software reset
    w = '{12'h010, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0};
    frame("R3 after reset", 4'd2, 1, w, 0, 0);

    repeat (20) @(negedge clk);
    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule